// File: doc/BRIEF.md
# USB Frame Scheduler with Backlog Catch-Up

This block produces the sequence of 1 ms frames for a full-speed USB host controller. A time base divides the clock into frame periods, and each elapsed period adds one entry to a backlog of frames that still need service. A service pass starts one frame period after the previous pass finished. A pass works through the backlog one frame at a time. For each frame it pulses a frame-start strobe to an external schedule walker, waits for that walker's done handshake, and then moves the 11-bit frame number on by one. The frame number therefore always names the frame that is currently in progress.

When the host falls far behind, a pass first drops the part of the backlog above a programmable ceiling. It moves the frame number past the dropped frames and does not strobe them. A pass also serves no more than a fixed number of frames in a row, so the walker cannot be starved of idle time. Interrupt causes reported by the walker are gathered during operation. At the end of each pass the gathered causes are folded into a sticky status field, and a summary interrupt bit is set. While the controller is stopped, the backlog is held empty and no frame is served.

Top module: `fs_frame_sched`

## Requirements
- R1: After reset the frame number is 0, the frame-start strobe is low, the summary interrupt bit is 0 and the cause field is all zero.
- R2: Each walker done handshake that ends a served frame advances the frame number by exactly one, modulo 2048. Frame 2047 is followed by frame 0.
- R3: The frame-start strobe is one clock wide. It is raised once per served frame, and the frame number does not change in the cycle that follows the strobe.
- R4: While run is low, no strobe is raised and the frame number holds its value. A frame that was aborted by a stop is served again, under the same number, after run returns high.
- R5: The time base and the pass timer both restart when run rises. The first strobe appears in the (CLK_PER_FRAME+1)-th clock after run is first sampled high.
- R6: One service pass raises at most BATCH_MAX strobes.
- R7: If the backlog is larger than max_backlog when a pass starts, the excess is discarded. The frame number jumps forward by the excess with no strobes, and the pass then serves at most max_backlog frames.
- R8: At the end of a pass, a nonzero set of gathered causes is ORed into stat_cause (bit i comes from int_cause bit i), and stat_usbint is set. Causes gathered after a pass has finished stay out of the status until the next pass ends.
- R9: A status_clear pulse clears stat_cause and stat_usbint. A later pass with no gathered causes leaves them at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 = schedule running, 0 = stopped |
| max_backlog | input | BL_W | Largest backlog kept at the start of a pass |
| int_cause | input | CAUSE_W | Interrupt causes raised by the walker, one bit per cause |
| walker_done | input | 1 | Walker has finished the current frame |
| status_clear | input | 1 | Clears the sticky interrupt status |
| frame_num | output | 11 | Number of the frame in progress |
| frame_start | output | 1 | One-cycle strobe asking the walker to process a frame |
| stat_usbint | output | 1 | Summary interrupt bit |
| stat_cause | output | CAUSE_W | Sticky interrupt cause field |

## Verification
The bench builds the block with a 20-clock frame period, a batch limit of 16 and a 10-bit backlog. At that size, a walker stall of a few dozen periods is enough to drive the backlog past the batch limit and past a small programmed ceiling, so both the cap and the skip can be reached in a short run. The short period also lets a plain run cross the 2047-to-0 frame number wrap within about 2100 frames. Strobe spacing, frame number jumps and first-strobe latency are all compared with values that the bench works out from the period and the walker delay.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int FN_W    = 11;
    localparam int CAUSE_W = 2;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_EVAL,
        FS_STROBE,
        FS_WAIT,
        FS_FINISH
    } fs_state_e;

    typedef struct packed {
        logic               usbint;
        logic [CAUSE_W-1:0] cause;
    } fs_status_t;

    function automatic logic [FN_W-1:0] fn_advance(input logic [FN_W-1:0] fn,
                                                   input logic [FN_W-1:0] step);
        return fn + step;
    endfunction

endpackage

// File: rtl/fs_period_timer.sv
module fs_period_timer #(
    parameter int PERIOD = 48000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/fs_backlog.sv
module fs_backlog #(
    parameter int BL_W = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            tick,
    input  logic            skip_en,
    input  logic            dec,
    input  logic [BL_W-1:0] max_val,
    output logic [BL_W-1:0] excess,
    output logic [BL_W-1:0] avail
);
    localparam logic [BL_W-1:0] ALL1 = '1;

    logic [BL_W-1:0] cnt_q;
    logic            over;

    assign over   = cnt_q > max_val;
    assign excess = over ? (cnt_q - max_val) : '0;
    assign avail  = over ? max_val : cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (skip_en && over)
            cnt_q <= (tick && max_val != ALL1) ? max_val + 1'b1 : max_val;
        else if (tick && !dec)
            cnt_q <= (cnt_q == ALL1) ? cnt_q : cnt_q + 1'b1;
        else if (dec && !tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/fs_irq_status.sv
module fs_irq_status
    import fs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               merge,
    input  logic               clear,
    output fs_status_t         status
);
    logic [CAUSE_W-1:0] pend_q;
    fs_status_t         stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            stat_q <= '0;
        end else begin
            pend_q <= merge ? cause_in : (pend_q | cause_in);
            if (merge && pend_q != '0) begin
                stat_q.cause  <= (clear ? '0 : stat_q.cause) | pend_q;
                stat_q.usbint <= 1'b1;
            end else if (clear) begin
                stat_q <= '0;
            end
        end
    end

    assign status = stat_q;
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
    import fs_pkg::*;
#(
    parameter int BATCH_MAX = 16,
    parameter int BL_W      = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            pass_due,
    input  logic            walker_done,
    input  logic [BL_W-1:0] excess,
    input  logic [BL_W-1:0] avail,
    output logic            skip_en,
    output logic            dec,
    output logic            merge,
    output logic            frame_start,
    output logic            busy,
    output logic [FN_W-1:0] fnum
);
    localparam int BC_W = $clog2(BATCH_MAX + 1);

    fs_state_e       state_q;
    logic [BC_W-1:0] left_q;
    logic [FN_W-1:0] fnum_q;
    logic [BC_W-1:0] take;

    assign take = (avail > BL_W'(BATCH_MAX)) ? BC_W'(BATCH_MAX) : BC_W'(avail);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            left_q  <= '0;
            fnum_q  <= '0;
        end else if (!run) begin
            state_q <= FS_IDLE;
        end else begin
            case (state_q)
                FS_IDLE:   if (pass_due) state_q <= FS_EVAL;
                FS_EVAL: begin
                    fnum_q  <= fn_advance(fnum_q, FN_W'(excess));
                    left_q  <= take;
                    state_q <= (take == '0) ? FS_FINISH : FS_STROBE;
                end
                FS_STROBE: state_q <= FS_WAIT;
                FS_WAIT: begin
                    if (walker_done) begin
                        fnum_q  <= fn_advance(fnum_q, FN_W'(1));
                        left_q  <= left_q - 1'b1;
                        state_q <= (left_q == BC_W'(1)) ? FS_FINISH : FS_STROBE;
                    end
                end
                FS_FINISH: state_q <= FS_IDLE;
                default:   state_q <= FS_IDLE;
            endcase
        end
    end

    assign skip_en     = run && state_q == FS_EVAL;
    assign dec         = run && state_q == FS_WAIT && walker_done;
    assign merge       = run && state_q == FS_FINISH;
    assign frame_start = state_q == FS_STROBE;
    assign busy        = state_q != FS_IDLE;
    assign fnum        = fnum_q;
endmodule

// File: rtl/fs_frame_sched.sv
module fs_frame_sched
    import fs_pkg::*;
#(
    parameter int CLK_PER_FRAME = 48000,
    parameter int BATCH_MAX     = 16,
    parameter int BL_W          = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [BL_W-1:0]    max_backlog,
    input  logic [CAUSE_W-1:0] int_cause,
    input  logic               walker_done,
    input  logic               status_clear,
    output logic [FN_W-1:0]    frame_num,
    output logic               frame_start,
    output logic               stat_usbint,
    output logic [CAUSE_W-1:0] stat_cause
);
    logic            frame_tick;
    logic            pass_due;
    logic            skip_en;
    logic            dec;
    logic            merge;
    logic            busy;
    logic [BL_W-1:0] excess;
    logic [BL_W-1:0] avail;
    fs_status_t      status;

    fs_period_timer #(.PERIOD(CLK_PER_FRAME)) u_timebase (
        .clk (clk),
        .rst (rst),
        .en  (run),
        .tick(frame_tick)
    );

    fs_period_timer #(.PERIOD(CLK_PER_FRAME)) u_pass_timer (
        .clk (clk),
        .rst (rst),
        .en  (run && !busy),
        .tick(pass_due)
    );

    fs_backlog #(.BL_W(BL_W)) u_backlog (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (frame_tick),
        .skip_en(skip_en),
        .dec    (dec),
        .max_val(max_backlog),
        .excess (excess),
        .avail  (avail)
    );

    fs_ctrl #(.BATCH_MAX(BATCH_MAX), .BL_W(BL_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .pass_due   (pass_due),
        .walker_done(walker_done),
        .excess     (excess),
        .avail      (avail),
        .skip_en    (skip_en),
        .dec        (dec),
        .merge      (merge),
        .frame_start(frame_start),
        .busy       (busy),
        .fnum       (frame_num)
    );

    fs_irq_status u_irq (
        .clk     (clk),
        .rst     (rst),
        .cause_in(int_cause),
        .merge   (merge),
        .clear   (status_clear),
        .status  (status)
    );

    assign stat_usbint = status.usbint;
    assign stat_cause  = status.cause;
endmodule

// File: rtl/fs_frame_sched_chk.sv
module fs_frame_sched_chk
    import fs_pkg::*;
#(
    parameter int BATCH_MAX = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               run,
    input logic               busy,
    input logic               frame_start,
    input logic [FN_W-1:0]    frame_num,
    input logic               stat_usbint,
    input logic [CAUSE_W-1:0] stat_cause
);
    localparam int SW = $clog2(BATCH_MAX + 2) + 1;
    logic [SW-1:0] strobes_q;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            strobes_q <= '0;
        else if (frame_start)
            strobes_q <= strobes_q + 1'b1;
    end

    // R3
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    // R3
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> $stable(frame_num));

    // R4
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !frame_start);

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(frame_num));

    // R6
    batch_cap_chk: assert property (@(posedge clk) disable iff (rst)
        strobes_q <= SW'(BATCH_MAX));

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_usbint) |-> (stat_cause != '0));
endmodule

bind fs_frame_sched fs_frame_sched_chk #(.BATCH_MAX(BATCH_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .busy       (busy),
    .frame_start(frame_start),
    .frame_num  (frame_num),
    .stat_usbint(stat_usbint),
    .stat_cause (stat_cause)
);

// File: tb/fs_frame_sched_test.sv
module fs_frame_sched_test;
    localparam int P    = 20;
    localparam int BMAX = 16;
    localparam int BLW  = 10;
    localparam int DLY  = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           run = 1'b0;
    logic [BLW-1:0] max_backlog = BLW'(100);
    logic [1:0]     int_cause = '0;
    logic           walker_done = 1'b0;
    logic           status_clear = 1'b0;
    logic [10:0]    frame_num;
    logic           frame_start;
    logic           stat_usbint;
    logic [1:0]     stat_cause;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  cyc = 0;

    int  nstrobe = 0;
    int  last_cyc = -1000;
    int  prev_fn = -1;
    int  burst = 0;
    int  max_burst = 0;
    int  max_jump = 0;
    bit  allow_skip = 1'b0;
    bit  resync = 1'b0;
    int  halt_fn = 0;
    bit  wrap_seen = 1'b0;
    bit  stall = 1'b0;
    int  cd = 0;
    bit  owed = 1'b0;

    fs_frame_sched #(.CLK_PER_FRAME(P), .BATCH_MAX(BMAX), .BL_W(BLW)) uut (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .max_backlog (max_backlog),
        .int_cause   (int_cause),
        .walker_done (walker_done),
        .status_clear(status_clear),
        .frame_num   (frame_num),
        .frame_start (frame_start),
        .stat_usbint (stat_usbint),
        .stat_cause  (stat_cause)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    endtask

    // Walker model and strobe monitor
    always @(negedge clk) begin
        if (walker_done) walker_done = 1'b0;
        if (frame_start) begin
            nstrobe++;
            if (resync) begin
                // R4: aborted frame served again under the same number
                check(int'(frame_num) == halt_fn, "R4 resume number", frame_num, halt_fn);
                resync = 1'b0;
            end else if (prev_fn >= 0) begin
                int jump;
                jump = (int'(frame_num) - prev_fn + 2048) % 2048;
                if (allow_skip) begin
                    // R7: number only moves forward
                    check(jump >= 1, "R7 jump", jump, 1);
                    if (jump > max_jump) max_jump = jump;
                end else begin
                    // R2: next strobe names the next frame
                    check(jump == 1, "R2 step", frame_num, (prev_fn + 1) % 2048);
                end
                if (prev_fn == 2047 && frame_num == 11'd0) wrap_seen = 1'b1;
            end
            if (cyc - last_cyc < P) burst++;
            else burst = 1;
            if (burst > max_burst) max_burst = burst;
            last_cyc = cyc;
            prev_fn = int'(frame_num);
            cd = DLY;
        end else if (cd > 0) begin
            cd--;
            if (cd == 0) owed = 1'b1;
        end
        if (owed && !stall) begin
            walker_done = 1'b1;
            owed = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 200000);
        summary();
    end

    initial begin
        int c0;
        int s0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(frame_num == 11'd0, "R1 frame_num", frame_num, 0);
        check(!frame_start, "R1 frame_start", frame_start, 0);
        check(!stat_usbint, "R1 usbint", stat_usbint, 0);
        check(stat_cause == 2'b00, "R1 cause", stat_cause, 0);

        // R4: stopped after reset, nothing happens
        repeat (3 * P) @(negedge clk);
        check(nstrobe == 0, "R4 idle strobes", nstrobe, 0);
        check(frame_num == 11'd0, "R4 idle number", frame_num, 0);

        // R5: first strobe latency after run rises
        c0 = cyc;
        run = 1'b1;
        while (nstrobe == 0) @(negedge clk);
        check(last_cyc - c0 == P + 1, "R5 first strobe", last_cyc - c0, P + 1);
        check(prev_fn == 0, "R2 first number", prev_fn, 0);

        // R2: long plain run across the 2047 -> 0 wrap
        while (nstrobe < 2100) @(negedge clk);
        check(wrap_seen, "R2 wrap", wrap_seen, 1);

        // R6: stall the walker, then count the longest back-to-back burst
        stall = 1'b1;
        repeat (40 * P) @(negedge clk);
        max_burst = 0;
        stall = 1'b0;
        repeat (20 * P) @(negedge clk);
        check(max_burst == BMAX, "R6 burst cap", max_burst, BMAX);

        // R7: small ceiling, stall, the excess is skipped
        repeat (10 * P) @(negedge clk);
        max_backlog = BLW'(5);
        stall = 1'b1;
        repeat (30 * P) @(negedge clk);
        max_burst = 0;
        max_jump = 0;
        allow_skip = 1'b1;
        stall = 1'b0;
        repeat (10 * P) @(negedge clk);
        allow_skip = 1'b0;
        check(max_burst == 5, "R7 burst after skip", max_burst, 5);
        check(max_jump >= 20 && max_jump <= 35, "R7 skip size", max_jump, 28);
        max_backlog = BLW'(100);
        repeat (10 * P) @(negedge clk);

        // R4: stop, hold, resume
        run = 1'b0;
        repeat (2) @(negedge clk);
        halt_fn = int'(frame_num);
        s0 = nstrobe;
        repeat (5 * P) @(negedge clk);
        check(nstrobe == s0, "R4 no strobe halted", nstrobe, s0);
        check(int'(frame_num) == halt_fn, "R4 number held", frame_num, halt_fn);
        resync = 1'b1;
        c0 = cyc;
        run = 1'b1;
        while (nstrobe == s0) @(negedge clk);
        check(last_cyc - c0 == P + 1, "R5 restart latency", last_cyc - c0, P + 1);
        repeat (5 * P) @(negedge clk);

        // R8: causes appear only after a pass ends
        int_cause = 2'b10;
        @(negedge clk);
        int_cause = 2'b00;
        check(!stat_usbint && stat_cause == 2'b00, "R8 not early", stat_cause, 0);
        repeat (3 * P) @(negedge clk);
        check(stat_usbint, "R8 usbint", stat_usbint, 1);
        check(stat_cause == 2'b10, "R8 cause", stat_cause, 2);

        // R9: clear, then a pass with no causes keeps it clear
        status_clear = 1'b1;
        @(negedge clk);
        status_clear = 1'b0;
        check(!stat_usbint && stat_cause == 2'b00, "R9 cleared", stat_cause, 0);
        repeat (3 * P) @(negedge clk);
        check(!stat_usbint && stat_cause == 2'b00, "R9 stays clear", stat_cause, 0);

        // R8: two causes in separate cycles accumulate
        int_cause = 2'b01;
        @(negedge clk);
        int_cause = 2'b10;
        @(negedge clk);
        int_cause = 2'b00;
        repeat (3 * P) @(negedge clk);
        check(stat_cause == 2'b11, "R8 accumulate", stat_cause, 3);
        check(stat_usbint, "R8 usbint again", stat_usbint, 1);

        summary();
    end
endmodule